// File: doc/BRIEF.md
# Masked Set/Clear General-Purpose Output Port

This block is a general-purpose output port with one register bit per pin. Software never writes the register directly. It issues a command strobe that carries a code and a mask byte. One code turns on every register bit whose mask bit is 1. Another code turns off every register bit whose mask bit is 1. Two further codes turn one channel's request-to-send bit on or off, with the channel given by a separate select input. All other register bits keep their values. The register can be read back at all times.

The pins are active low. A pin that takes its value from the register shows the inverse of its register bit, so a set bit pulls the pin low.

The lowest pins, one per serial channel, can also be gated by internal channel status:
- When receiver flow control is on, the pin is the NAND of the register bit and the receiver's request-to-send signal.
- When transmitter-empty control is on, an empty transmitter releases the pin high.
- When both are on, the pin reflects both conditions.

Each of the remaining pins has a per-pin select bit. The select bit chooses between the inverted register bit and an inverted internal status line. Turning a gating mode on or off never alters the register, so the pin returns to plain register control as soon as the mode is cleared.

Top module: `out_port_setclr`

## Requirements
- R1: A strobe with code 4'hE sets every register bit whose mask bit is 1 and leaves the other bits unchanged. The result is visible on `reg_q` after the next rising clock edge.
- R2: A strobe with code 4'hF clears every register bit whose mask bit is 1 and leaves the other bits unchanged.
- R3: Code 4'h8 sets register bit `cmd_chan`, and code 4'h9 clears register bit `cmd_chan`. The mask is ignored for these codes, and only that one bit changes.
- R4: A strobe with any other code, or any input while `cmd_valid` is 0, leaves the register unchanged.
- R5: A pin whose source is the register is driven to the inverse of its register bit.
- R6: With receiver flow control enabled for channel c, pin c is low only when register bit c is 1 and `rx_rts[c]` is 1.
- R7: Changing `rts_flow_en` or `txemt_ctl_en` never changes the register. With both modes off, a channel pin follows R5 again.
- R8: With transmitter-empty control enabled for channel c, pin c is high whenever `tx_empty[c]` is 1. Otherwise pin c is low when register bit c is 1.
- R9: With both modes enabled for channel c, pin c is low only when register bit c is 1, `rx_rts[c]` is 1 and `tx_empty[c]` is 0.
- R10: For each upper pin k, select bit `alt_sel[k-NUM_CHAN]`=1 drives the pin to the inverse of `alt_src[k-NUM_CHAN]`. Select bit 0 drives the pin to the inverse of register bit k. An unselected status line has no effect on its pin.
- R11: Synchronous reset clears the register to all zeros, so every pin reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 4 | Command code |
| cmd_chan | input | CHAN_W | Channel select for the request-to-send codes |
| cmd_mask | input | PORT_W | Bit mask for the set and clear codes |
| rts_flow_en | input | NUM_CHAN | Per channel: receiver flow control gates the channel pin |
| txemt_ctl_en | input | NUM_CHAN | Per channel: transmitter-empty gates the channel pin |
| alt_sel | input | PORT_W-NUM_CHAN | Per upper pin: 1 selects the internal status line |
| rx_rts | input | NUM_CHAN | Receiver request-to-send, active high |
| tx_empty | input | NUM_CHAN | Transmitter empty, active high |
| alt_src | input | PORT_W-NUM_CHAN | Internal status lines for the upper pins, active high |
| pin_n | output | PORT_W | Active-low output pins |
| reg_q | output | PORT_W | Register readback |

## Verification
The bench builds the block with its defaults: an 8-bit port and two channels. This gives two gated channel pins and six selectable pins, so every pin kind and both request-to-send command targets occur. The run uses the full mask byte and directed mode combinations, including both gates on one channel at once. A randomized stretch then mixes commands with mode and status changes. This stretch shows that mode toggles leave the register alone while unselected status lines move.

// File: rtl/oport_pkg.sv
package oport_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_RTS_ON  = 4'h8;
    localparam logic [CODE_W-1:0] CODE_RTS_OFF = 4'h9;
    localparam logic [CODE_W-1:0] CODE_SET     = 4'hE;
    localparam logic [CODE_W-1:0] CODE_CLR     = 4'hF;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_SET,
        KIND_CLR,
        KIND_RTS_ON,
        KIND_RTS_OFF
    } cmd_kind_e;

    function automatic cmd_kind_e classify(input logic [CODE_W-1:0] code);
        cmd_kind_e k;
        case (code)
            CODE_SET:     k = KIND_SET;
            CODE_CLR:     k = KIND_CLR;
            CODE_RTS_ON:  k = KIND_RTS_ON;
            CODE_RTS_OFF: k = KIND_RTS_OFF;
            default:      k = KIND_NONE;
        endcase
        return k;
    endfunction

    // Gate term for a channel pin: 1 lets the register bit pull the pin low.
    function automatic logic chan_gate(input logic flow_en, input logic rts,
                                       input logic tx_en, input logic empty);
        logic g_rx;
        logic g_tx;
        g_rx = flow_en ? rts : 1'b1;
        g_tx = tx_en ? ~empty : 1'b1;
        return g_rx & g_tx;
    endfunction

endpackage

// File: rtl/opr_cmd_decode.sv
module opr_cmd_decode
    import oport_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int NUM_CHAN = 2,
    localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic [PORT_W-1:0] cmd_mask,
    output logic [PORT_W-1:0] set_mask,
    output logic [PORT_W-1:0] clr_mask
);

    cmd_kind_e kind;
    logic [PORT_W-1:0] chan_bit;

    always_comb begin
        kind = classify(cmd_code);
        chan_bit = '0;
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (cmd_chan == CHAN_W'(c)) chan_bit[c] = 1'b1;
        end
    end

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (cmd_valid) begin
            case (kind)
                KIND_SET:     set_mask = cmd_mask;
                KIND_CLR:     clr_mask = cmd_mask;
                KIND_RTS_ON:  set_mask = chan_bit;
                KIND_RTS_OFF: clr_mask = chan_bit;
                default: ;
            endcase
        end
    end

    // R3: a request-to-send code never touches more than one bit
    always_comb begin
        if (cmd_valid && (kind == KIND_RTS_ON || kind == KIND_RTS_OFF))
            a_r3_single_bit: assert ($countones(set_mask | clr_mask) <= 1);
    end

endmodule

// File: rtl/opr_bank.sv
module opr_bank #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] set_mask,
    input  logic [PORT_W-1:0] clr_mask,
    output logic [PORT_W-1:0] reg_q
);

    always_ff @(posedge clk) begin
        if (rst) reg_q <= '0;
        else     reg_q <= (reg_q & ~clr_mask) | set_mask;
    end

    a_r1_set_bits_high: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((reg_q & $past(set_mask)) == $past(set_mask)));

    a_r2_clear_bits_low: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((reg_q & $past(clr_mask)) == '0));

    a_r4_no_cmd_holds: assert property (@(posedge clk) disable iff (rst)
        (set_mask == '0 && clr_mask == '0) |=> $stable(reg_q));

    a_r1_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((reg_q & ~$past(set_mask | clr_mask))
                  == ($past(reg_q) & ~$past(set_mask | clr_mask))));

    a_r11_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (reg_q == '0));

endmodule

// File: rtl/opr_pin_mux.sv
module opr_pin_mux
    import oport_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int NUM_CHAN = 2,
    localparam int ALT_W   = PORT_W - NUM_CHAN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PORT_W-1:0]   reg_q,
    input  logic [NUM_CHAN-1:0] rts_flow_en,
    input  logic [NUM_CHAN-1:0] txemt_ctl_en,
    input  logic [NUM_CHAN-1:0] rx_rts,
    input  logic [NUM_CHAN-1:0] tx_empty,
    input  logic [ALT_W-1:0]    alt_sel,
    input  logic [ALT_W-1:0]    alt_src,
    output logic [PORT_W-1:0]   pin_n
);

    genvar g;
    generate
        for (g = 0; g < NUM_CHAN; g++) begin : g_chan
            logic gate;
            assign gate = chan_gate(rts_flow_en[g], rx_rts[g],
                                    txemt_ctl_en[g], tx_empty[g]);
            assign pin_n[g] = ~(reg_q[g] & gate);

            a_r6_pin_needs_reg: assert property (@(posedge clk) disable iff (rst)
                !reg_q[g] |-> pin_n[g]);

            a_r8_empty_releases: assert property (@(posedge clk) disable iff (rst)
                (txemt_ctl_en[g] && tx_empty[g]) |-> pin_n[g]);
        end

        for (g = NUM_CHAN; g < PORT_W; g++) begin : g_upper
            assign pin_n[g] = alt_sel[g-NUM_CHAN] ? ~alt_src[g-NUM_CHAN] : ~reg_q[g];

            a_r10_unselected_reg: assert property (@(posedge clk) disable iff (rst)
                !alt_sel[g-NUM_CHAN] |-> (pin_n[g] != reg_q[g]));
        end
    endgenerate

endmodule

// File: rtl/out_port_setclr.sv
module out_port_setclr
    import oport_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int NUM_CHAN = 2,
    localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
    localparam int ALT_W   = PORT_W - NUM_CHAN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_code,
    input  logic [CHAN_W-1:0]   cmd_chan,
    input  logic [PORT_W-1:0]   cmd_mask,
    input  logic [NUM_CHAN-1:0] rts_flow_en,
    input  logic [NUM_CHAN-1:0] txemt_ctl_en,
    input  logic [ALT_W-1:0]    alt_sel,
    input  logic [NUM_CHAN-1:0] rx_rts,
    input  logic [NUM_CHAN-1:0] tx_empty,
    input  logic [ALT_W-1:0]    alt_src,
    output logic [PORT_W-1:0]   pin_n,
    output logic [PORT_W-1:0]   reg_q
);

    logic [PORT_W-1:0] set_mask;
    logic [PORT_W-1:0] clr_mask;

    opr_cmd_decode #(.PORT_W(PORT_W), .NUM_CHAN(NUM_CHAN)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_chan  (cmd_chan),
        .cmd_mask  (cmd_mask),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask)
    );

    opr_bank #(.PORT_W(PORT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .reg_q    (reg_q)
    );

    opr_pin_mux #(.PORT_W(PORT_W), .NUM_CHAN(NUM_CHAN)) u_mux (
        .clk          (clk),
        .rst          (rst),
        .reg_q        (reg_q),
        .rts_flow_en  (rts_flow_en),
        .txemt_ctl_en (txemt_ctl_en),
        .rx_rts       (rx_rts),
        .tx_empty     (tx_empty),
        .alt_sel      (alt_sel),
        .alt_src      (alt_src),
        .pin_n        (pin_n)
    );

    // R7: mode inputs alone never move the register
    a_r7_mode_no_reg: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && !$stable(rts_flow_en ^ txemt_ctl_en)) |=> $stable(reg_q));

    // R11: all pins high out of reset
    a_r11_pins_high: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && alt_sel == '0) |-> (pin_n == '1));

endmodule

// File: tb/out_port_setclr_tb.sv
module out_port_setclr_tb;

    localparam int PW = 8;
    localparam int NC = 2;
    localparam int AW = PW - NC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_code = 4'h0;
    logic [0:0]    cmd_chan = 1'b0;
    logic [PW-1:0] cmd_mask = '0;
    logic [NC-1:0] rts_flow_en = '0;
    logic [NC-1:0] txemt_ctl_en = '0;
    logic [AW-1:0] alt_sel = '0;
    logic [NC-1:0] rx_rts = '0;
    logic [NC-1:0] tx_empty = '0;
    logic [AW-1:0] alt_src = '0;
    logic [PW-1:0] pin_n;
    logic [PW-1:0] reg_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [PW-1:0] model = '0;

    always #5 clk = ~clk;

    out_port_setclr #(.PORT_W(PW), .NUM_CHAN(NC)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_chan(cmd_chan), .cmd_mask(cmd_mask), .rts_flow_en(rts_flow_en),
        .txemt_ctl_en(txemt_ctl_en), .alt_sel(alt_sel), .rx_rts(rx_rts),
        .tx_empty(tx_empty), .alt_src(alt_src), .pin_n(pin_n), .reg_q(reg_q)
    );

    function automatic logic [PW-1:0] expect_pins();
        logic [PW-1:0] p;
        for (int i = 0; i < PW; i++) begin
            if (i < NC) begin
                bit low = model[i];
                if (rts_flow_en[i] && !rx_rts[i]) low = 0;
                if (txemt_ctl_en[i] && tx_empty[i]) low = 0;
                p[i] = !low;
            end else if (alt_sel[i-NC]) begin
                p[i] = !alt_src[i-NC];
            end else begin
                p[i] = !model[i];
            end
        end
        return p;
    endfunction

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic cycle(input string tag);
        @(posedge clk);
        if (rst) model = '0;
        else if (cmd_valid) begin
            case (cmd_code)
                4'hE: model = model | cmd_mask;
                4'hF: model = model & ~cmd_mask;
                4'h8: model[cmd_chan] = 1'b1;
                4'h9: model[cmd_chan] = 1'b0;
                default: ;
            endcase
        end
        @(negedge clk);
        checks++;
        if (reg_q !== model) begin
            errors++;
            $display("FAIL %s reg_q actual %h expected %h", tag, reg_q, model);
        end
        checks++;
        if (pin_n !== expect_pins()) begin
            errors++;
            $display("FAIL %s pin_n actual %h expected %h", tag, pin_n, expect_pins());
        end
    endtask

    task automatic cmd(input logic [3:0] code, input logic [PW-1:0] mask,
                       input logic ch, input string tag);
        cmd_valid = 1'b1; cmd_code = code; cmd_mask = mask; cmd_chan = ch;
        cycle(tag);
        cmd_valid = 1'b0;
        cycle(tag);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 4'hE; cmd_mask = '1;
        cycle("R11 reset ignores command");
        cycle("R11 reset");
        cmd_valid = 1'b0;
        rst = 1'b0;
        cycle("R11 after reset");

        cmd(4'hE, 8'hA5, 0, "R1 set A5");
        cmd(4'hE, 8'h0F, 0, "R1 set 0F");
        cmd(4'hF, 8'h21, 0, "R2 clear 21");
        cmd(4'hF, 8'hFF, 0, "R2 clear all");
        cmd(4'hE, 8'h3C, 0, "R5 pins inverse");

        cmd(4'h0, 8'hFF, 0, "R4 code 0");
        cmd(4'h3, 8'hFF, 0, "R4 code 3");
        cmd(4'hA, 8'hFF, 1, "R4 code A");
        cmd(4'hD, 8'h00, 0, "R4 code D");
        cmd_code = 4'hF; cmd_mask = 8'hFF;
        cycle("R4 strobe low");

        cmd(4'h8, 8'h00, 0, "R3 rts on A");
        cmd(4'h8, 8'hF0, 1, "R3 rts on B");
        cmd(4'h9, 8'hFF, 0, "R3 rts off A");
        cmd(4'h9, 8'h00, 1, "R3 rts off B");

        cmd(4'hE, 8'h03, 0, "R6 prep");
        rts_flow_en = 2'b11; rx_rts = 2'b00;
        cycle("R6 rts low");
        rx_rts = 2'b01; cycle("R6 rts A");
        rx_rts = 2'b11; cycle("R6 rts both");
        cmd(4'hF, 8'h01, 0, "R6 reg off");
        rts_flow_en = 2'b00; cycle("R7 flow off");
        rts_flow_en = 2'b11; cycle("R7 flow on");
        rts_flow_en = 2'b00; rx_rts = 2'b00; cycle("R7 back to reg");

        cmd(4'hE, 8'h03, 0, "R8 prep");
        txemt_ctl_en = 2'b11; tx_empty = 2'b11; cycle("R8 empty");
        tx_empty = 2'b10; cycle("R8 A busy");
        tx_empty = 2'b00; cycle("R8 busy");
        rts_flow_en = 2'b11; rx_rts = 2'b01; cycle("R9 both gates");
        tx_empty = 2'b01; cycle("R9 both gates A empty");
        rx_rts = 2'b11; tx_empty = 2'b00; cycle("R9 all open");
        rts_flow_en = '0; txemt_ctl_en = '0; cycle("R7 modes off");

        cmd(4'hE, 8'hF0, 0, "R10 prep");
        alt_src = 6'b101010; cycle("R10 unselected src");
        alt_sel = 6'b001111; cycle("R10 partial select");
        alt_src = 6'b010101; cycle("R10 src change");
        alt_sel = 6'b111111; cycle("R10 all selected");
        alt_sel = '0; cycle("R10 deselect");

        for (int n = 0; n < 400; n++) begin
            cmd_valid    = $urandom_range(0, 1);
            cmd_code     = 4'($urandom);
            if ($urandom_range(0, 1) == 1) cmd_code = {3'b111, 1'($urandom)};
            cmd_mask     = PW'($urandom);
            cmd_chan     = 1'($urandom);
            rts_flow_en  = NC'($urandom);
            txemt_ctl_en = NC'($urandom);
            rx_rts       = NC'($urandom);
            tx_empty     = NC'($urandom);
            alt_sel      = AW'($urandom);
            alt_src      = AW'($urandom);
            cycle("R1 R2 R3 R6 R7 R8 R9 R10 mixed");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule